// File: doc/BRIEF.md
# Chip Erase Sequencer with Verify and Retry

This block runs a complete electrical erase of a byte-wide nonvolatile memory. A single start pulse begins the run. The block raises the memory's supply and then its programming high voltage. It issues a two-write unlock command, and the second write's strobe is much longer than the first. It then drops the high voltage and reads the memory one location at a time, starting from address zero, until every byte reads 0xFF. If any read is not blank, the block starts the whole erase again. A counter limits the number of erases.

When every location verifies, the block returns the supply to its normal level and checks the whole array for 0xFF once more. The result of this last check decides between pass and fail. If the erase limit is reached, the run ends in fail. The supply switch, the high-voltage switch and the memory are outside the block. The block drives their enables, the write strobe, the address and write data, and the read enable, and it samples the read data.

All pulse lengths, setup gaps and the read settle delay are counts of clock cycles set by parameters.

Top module: `erase_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, `busy_o`, `supply_hi_o`, `hv_en_o`, `wr_stb_o` and `rd_en_o` are all low.
- R2: A start pulse raises `supply_hi_o` in the next cycle. `hv_en_o` is high only while `supply_hi_o` is high, and `supply_hi_o` never falls in the cycle after a cycle in which `hv_en_o` was high.
- R3: Each erase begins with a first write strobe: `mem_addr_o` holds the low ADDR_W bits of 0x5555 and `mem_wdata_o` holds 0xAA, for exactly P1_CYC cycles.
- R4: The first write is followed by a second write strobe: `mem_addr_o` holds the low ADDR_W bits of 0x2AAA and `mem_wdata_o` holds 0x10, for exactly P2_CYC cycles. An erase counts as issued when this second strobe ends.
- R5: `wr_stb_o` is high only while `hv_en_o` is high, and `rd_en_o` is never high while `hv_en_o` is high.
- R6: Every read sweep starts at address 0 and steps up by one. Read data is sampled only after `rd_en_o` has held the same address for EOE_CYC cycles.
- R7: When a verify read is not 0xFF, the erase counter is incremented. A new erase starts unless the count has reached MAX_TRIES, in which case the run ends with `fail_o`.
- R8: After the last address verifies at the raised supply, `supply_hi_o` falls and the whole array is read again. The run ends with `pass_o` only if every byte reads 0xFF; otherwise it ends with `fail_o`.
- R9: A start pulse during a run has no effect on that run.
- R10: `pass_o` and `fail_o` are never both high. Both are low while busy, and the result is held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start an erase run (used only when idle) |
| mem_rdata_i | input | 8 | Read data from the memory |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run ended blank |
| fail_o | output | 1 | Last run ended in failure |
| supply_hi_o | output | 1 | Raised-supply enable |
| hv_en_o | output | 1 | High-voltage enable on the program pin |
| wr_stb_o | output | 1 | Write strobe |
| rd_en_o | output | 1 | Read (output) enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Command write data |

## Verification
The bench's memory model reports blank only after a chosen number of issued erases, and it returns 0x00 until the read address has settled for the full delay. A sequencer that samples early would therefore retry or fail. A sequencer that miscounts its erases would report the wrong result around the limit: the bench uses exactly MAX_TRIES erases and one more than that. A fault seen only at normal supply catches a design that skips the final check or keeps the supply raised during it. Pulse widths, command order, the voltage ordering, the start address of each sweep and a start pulse sent mid-run are each checked, because a wrong sequencer would get the strobe lengths wrong, restart, or leave the supply raised under high voltage.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VUP,
        ST_CMD1,
        ST_GAP1,
        ST_CMD2,
        ST_GAP2,
        ST_HVDN,
        ST_VFY,
        ST_NORM,
        ST_BLANK
    } seq_state_t;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
    } cmd_word_t;

    localparam logic [15:0] UNLOCK_A_ADDR = 16'h5555;
    localparam logic [7:0]  UNLOCK_A_DATA = 8'hAA;
    localparam logic [15:0] UNLOCK_B_ADDR = 16'h2AAA;
    localparam logic [7:0]  UNLOCK_B_DATA = 8'h10;
    localparam logic [7:0]  ERASED_BYTE   = 8'hFF;

    function automatic cmd_word_t cmd_for(input seq_state_t st);
        cmd_word_t c;
        c = '0;
        if (st == ST_CMD1 || st == ST_GAP1) begin
            c.addr = UNLOCK_A_ADDR;
            c.data = UNLOCK_A_DATA;
        end else if (st == ST_CMD2 || st == ST_GAP2) begin
            c.addr = UNLOCK_B_ADDR;
            c.data = UNLOCK_B_DATA;
        end
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/erase_seq_sweep.sv
module erase_seq_sweep #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = (addr == {AW{1'b1}});
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int P1_CYC    = 6250,
    parameter int P2_CYC    = 12500000,
    parameter int GAP_CYC   = 250,
    parameter int SET_CYC   = 250,
    parameter int EOE_CYC   = 2,
    parameter int MAX_TRIES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              supply_hi_o,
    output logic              hv_en_o,
    output logic              wr_stb_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);
    localparam int LONGEST = max_of(max_of(P1_CYC, P2_CYC),
                                    max_of(max_of(GAP_CYC, SET_CYC), EOE_CYC));
    localparam int TW = $clog2(LONGEST + 1);
    localparam int CW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] D_P1  = TW'(P1_CYC - 1);
    localparam logic [TW-1:0] D_P2  = TW'(P2_CYC - 1);
    localparam logic [TW-1:0] D_GAP = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] D_SET = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] D_EOE = TW'(EOE_CYC - 1);
    localparam logic [CW-1:0] TRY_LIMIT = CW'(MAX_TRIES);

    seq_state_t    state, state_nx;
    logic [CW-1:0] tries, tries_nx;
    logic          pass_q, fail_q, pass_nx, fail_nx;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          sw_clr, sw_inc, sw_last;
    logic [ADDR_W-1:0] sw_addr;
    logic          byte_blank;
    cmd_word_t     cmd;

    erase_seq_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    erase_seq_sweep #(.AW(ADDR_W)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .clr  (sw_clr),
        .inc  (sw_inc),
        .addr (sw_addr),
        .last (sw_last)
    );

    assign byte_blank = (mem_rdata_i == ERASED_BYTE);

    always_comb begin
        state_nx = state;
        tries_nx = tries;
        pass_nx  = pass_q;
        fail_nx  = fail_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sw_clr   = 1'b0;
        sw_inc   = 1'b0;
        unique case (state)
            ST_IDLE: if (start_i) begin
                state_nx = ST_VUP;
                tmr_load = 1'b1;
                tmr_val  = D_SET;
                tries_nx = '0;
                pass_nx  = 1'b0;
                fail_nx  = 1'b0;
            end
            ST_VUP: if (tmr_zero) begin
                state_nx = ST_CMD1;
                tmr_load = 1'b1;
                tmr_val  = D_P1;
            end
            ST_CMD1: if (tmr_zero) begin
                state_nx = ST_GAP1;
                tmr_load = 1'b1;
                tmr_val  = D_GAP;
            end
            ST_GAP1: if (tmr_zero) begin
                state_nx = ST_CMD2;
                tmr_load = 1'b1;
                tmr_val  = D_P2;
            end
            ST_CMD2: if (tmr_zero) begin
                state_nx = ST_GAP2;
                tmr_load = 1'b1;
                tmr_val  = D_GAP;
            end
            ST_GAP2: if (tmr_zero) begin
                state_nx = ST_HVDN;
                tmr_load = 1'b1;
                tmr_val  = D_SET;
                sw_clr   = 1'b1;
            end
            ST_HVDN: if (tmr_zero) begin
                state_nx = ST_VFY;
                tmr_load = 1'b1;
                tmr_val  = D_EOE;
            end
            ST_VFY: if (tmr_zero) begin
                if (byte_blank) begin
                    tmr_load = 1'b1;
                    if (sw_last) begin
                        state_nx = ST_NORM;
                        tmr_val  = D_SET;
                        sw_clr   = 1'b1;
                    end else begin
                        tmr_val  = D_EOE;
                        sw_inc   = 1'b1;
                    end
                end else if (tries + 1'b1 == TRY_LIMIT) begin
                    state_nx = ST_IDLE;
                    fail_nx  = 1'b1;
                end else begin
                    tries_nx = tries + 1'b1;
                    state_nx = ST_VUP;
                    tmr_load = 1'b1;
                    tmr_val  = D_SET;
                end
            end
            ST_NORM: if (tmr_zero) begin
                state_nx = ST_BLANK;
                tmr_load = 1'b1;
                tmr_val  = D_EOE;
            end
            ST_BLANK: if (tmr_zero) begin
                if (!byte_blank) begin
                    state_nx = ST_IDLE;
                    fail_nx  = 1'b1;
                end else if (sw_last) begin
                    state_nx = ST_IDLE;
                    pass_nx  = 1'b1;
                end else begin
                    sw_inc   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = D_EOE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tries  <= '0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            state  <= state_nx;
            tries  <= tries_nx;
            pass_q <= pass_nx;
            fail_q <= fail_nx;
        end
    end

    assign cmd         = cmd_for(state);
    assign busy_o      = (state != ST_IDLE);
    assign pass_o      = pass_q;
    assign fail_o      = fail_q;
    assign supply_hi_o = (state == ST_VUP)  || (state == ST_CMD1) || (state == ST_GAP1) ||
                         (state == ST_CMD2) || (state == ST_GAP2) || (state == ST_HVDN) ||
                         (state == ST_VFY);
    assign hv_en_o     = (state == ST_CMD1) || (state == ST_GAP1) ||
                         (state == ST_CMD2) || (state == ST_GAP2);
    assign wr_stb_o    = (state == ST_CMD1) || (state == ST_CMD2);
    assign rd_en_o     = (state == ST_VFY)  || (state == ST_BLANK);
    assign mem_addr_o  = rd_en_o ? sw_addr : ADDR_W'(cmd.addr);
    assign mem_wdata_o = cmd.data;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic pass_o,
    input logic fail_o,
    input logic supply_hi_o,
    input logic hv_en_o,
    input logic wr_stb_o,
    input logic rd_en_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!supply_hi_o && !hv_en_o && !wr_stb_o && !rd_en_o));

    p_hv_needs_supply_r2: assert property (@(posedge clk) disable iff (rst)
        hv_en_o |-> supply_hi_o);

    p_supply_after_hv_r2: assert property (@(posedge clk) disable iff (rst)
        hv_en_o |=> supply_hi_o);

    p_strobe_needs_hv_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> hv_en_o);

    p_read_without_hv_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> !hv_en_o);

    p_result_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    p_result_clear_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!pass_o && !fail_o));

    p_result_held_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && $past(!busy_o) && !$rose(busy_o)) |-> ($stable(pass_o) && $stable(fail_o)));
endmodule

bind erase_seq erase_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .supply_hi_o (supply_hi_o),
    .hv_en_o     (hv_en_o),
    .wr_stb_o    (wr_stb_o),
    .rd_en_o     (rd_en_o)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
    localparam int AW  = 3;
    localparam int P1  = 5;
    localparam int P2  = 11;
    localparam int GAP = 2;
    localparam int SET = 2;
    localparam int EOE = 3;
    localparam int MAXT = 4;
    localparam logic [AW-1:0] A1 = AW'(16'h5555);
    localparam logic [AW-1:0] A2 = AW'(16'h2AAA);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] rdata;
    logic busy, pass, fail, sup, hv, we, oe;
    logic [AW-1:0] addr;
    logic [7:0] wdata;

    int n_checks = 0;
    int n_errors = 0;

    int m_need = 1;
    int m_bad = 0;
    bit m_ffault = 1'b0;
    int m_ffaddr = 0;
    int erase_cnt = 0;
    int age = 0;
    int v_order = 0, v_rw = 0, v_pulse = 0, v_start = 0;
    int wlen = 0;
    logic [AW-1:0] waddr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0] wdat = '0;
    bit got_a = 1'b0;
    bit p_we = 1'b0, p_oe = 1'b0, p_sup = 1'b0, p_hv = 1'b0;

    always #4 clk = ~clk;

    erase_seq #(
        .ADDR_W(AW), .P1_CYC(P1), .P2_CYC(P2), .GAP_CYC(GAP),
        .SET_CYC(SET), .EOE_CYC(EOE), .MAX_TRIES(MAXT)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .mem_rdata_i(rdata),
        .busy_o(busy), .pass_o(pass), .fail_o(fail), .supply_hi_o(sup),
        .hv_en_o(hv), .wr_stb_o(we), .rd_en_o(oe),
        .mem_addr_o(addr), .mem_wdata_o(wdata)
    );

    function automatic logic [7:0] mem_val(input logic [AW-1:0] a, input logic s,
                                           input logic r, input int ec, input int ag);
        if (!r || ag < EOE) return 8'h00;
        if (ec < m_need && int'(a) == m_bad) return 8'h7F;
        if (!s && m_ffault && int'(a) == m_ffaddr) return 8'hFE;
        return 8'hFF;
    endfunction

    assign rdata = mem_val(addr, sup, oe, erase_cnt, age);

    always @(negedge clk) begin
        if (hv && !sup) v_order++;
        if (p_sup && !sup && p_hv) v_order++;
        if ((we && !hv) || (oe && hv)) v_rw++;
        if (oe && !p_oe && addr != '0) v_start++;
        if (oe) age = (p_oe && addr == last_addr) ? age + 1 : 1;
        else age = 0;
        last_addr = addr;
        if (we) begin
            if (wlen > 0 && (addr != waddr || wdata != wdat)) v_pulse++;
            wlen++; waddr = addr; wdat = wdata;
        end else if (p_we) begin
            if (wdat == 8'hAA) begin
                if (wlen != P1 || waddr != A1) v_pulse++;
                got_a = 1'b1;
            end else if (wdat == 8'h10) begin
                if (wlen != P2 || waddr != A2 || !got_a) v_pulse++;
                got_a = 1'b0;
                erase_cnt++;
            end else v_pulse++;
            wlen = 0;
        end
        p_we = we; p_oe = oe; p_sup = sup; p_hv = hv;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int need, input int bad, input bit ff, input int ffa, input bit poke);
        int exp_er;
        bit exp_pass;
        int guard;
        m_need = need; m_bad = bad; m_ffault = ff; m_ffaddr = ffa;
        erase_cnt = 0; v_order = 0; v_rw = 0; v_pulse = 0; v_start = 0;
        exp_er   = (need > MAXT) ? MAXT : need;
        exp_pass = (need <= MAXT) && !ff;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && sup && !hv, "R2 supply first", {busy, sup, hv}, 3'b110);
        if (poke) begin
            repeat (25) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(!busy, "R1 run ends", busy, 0);
        chk(!sup && !hv && !we && !oe, "R1 idle outputs", {sup, hv, we, oe}, 0);
        chk(erase_cnt == exp_er, poke ? "R9 erase count with start during run" : "R7 erase count",
            erase_cnt, exp_er);
        chk(pass == exp_pass && fail == !exp_pass, exp_pass ? "R8 pass" : "R8 fail",
            {pass, fail}, {exp_pass, !exp_pass});
        chk(v_order == 0, "R2 supply/hv ordering", v_order, 0);
        chk(v_rw == 0, "R5 strobe and read vs hv", v_rw, 0);
        chk(v_pulse == 0, "R3 R4 command pulses", v_pulse, 0);
        chk(v_start == 0, "R6 sweep starts at 0", v_start, 0);
        repeat (4) @(negedge clk);
        chk(pass == exp_pass && fail == !exp_pass, "R10 result held", {pass, fail},
            {exp_pass, !exp_pass});
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !pass && !fail && !sup && !hv && !we && !oe, "R1 reset state",
            {busy, pass, fail, sup, hv, we, oe}, 0);
        run(1, 0, 1'b0, 0, 1'b0);
        run(MAXT, 7, 1'b0, 0, 1'b0);
        run(MAXT + 1, 3, 1'b0, 0, 1'b0);
        run(2, 5, 1'b1, 7, 1'b0);
        run(1, 0, 1'b1, 0, 1'b0);
        run(3, 1, 1'b0, 0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            run(1 + int'($urandom_range(0, MAXT + 1)), int'($urandom_range(0, 7)),
                bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule